// File: doc/BRIEF.md
# Peripheral Bus Block-Transfer Controller

This block copies blocks of data between a word-wide main memory and a halfword-wide parallel peripheral bus, such as a cartridge slot. Software programs a memory address and a peripheral address. It then writes one of two length registers, and the register it picks sets the direction. Data moves in chunks of up to 32 words through an internal 128-byte staging buffer. Each chunk is first filled from the source side and then drained to the destination side. On completion the block raises an interrupt request, which stays up until software acknowledges it.

The peripheral bus is split into two address domains, selected by one bit of the peripheral address. Each domain has its own timing settings: how long the address phase lasts, how long the read or write strobe lasts, the page size, and the idle release time after each access. An address phase is issued only when an access leaves the current page. If the CPU touches the peripheral space directly while a transfer runs, a sticky error bit is latched. The transfer still finishes normally. Only a soft-reset write clears the error bit.

Top module: `pbus_dma`

## Requirements
- R1: The memory address register (index 0, offset 0x00) keeps 24 bits and reads bit 0 as zero. Writing 0xFFFFFFFF reads back 0x00FFFFFE, and writing 0x55555555 reads back 0x00555554.
- R2: The peripheral address register (index 1, offset 0x04) keeps all 32 bits except bit 0, which reads as zero. Writing 0xFFFFFFFF reads back 0xFFFFFFFE, and writing 0xAAAAAAAA reads back unchanged.
- R3: The status register is at index 4 (offset 0x10). Bit 0 is busy, bit 2 is error and bit 3 is interrupt pending, and all three are 0 after reset. Busy is 1 from the length write until the last word of the last chunk is written. No memory or peripheral request is active while idle.
- R4: Writing index 2 (offset 0x08) starts a memory-to-peripheral copy, and writing index 3 (offset 0x0C) starts a peripheral-to-memory copy. The value written is the byte count minus one, and the block moves floor(value/4)+1 words. While busy, writes to the length registers and the address registers are ignored.
- R5: In a peripheral-to-memory copy, the halfword read at the lower peripheral address becomes bits 31:16 of the memory word and the next halfword becomes bits 15:0. With bytes 00 01 02 03 on a bus that presents halfword {byte[a+1], byte[a]}, the stored word is 0x01000302.
- R6: In a memory-to-peripheral copy, bits 31:16 of each memory word are written at the lower peripheral address and bits 15:0 at that address plus 2.
- R7: Copies longer than 128 bytes run in chunks of at most 32 words and arrive intact. When a copy ends, each address register has advanced by the number of bytes moved.
- R8: A direct peripheral access attempt (ioAttempt) while busy sets status bit 2. The copy still completes with correct data. An attempt while idle has no effect.
- R9: Writing status with bit 0 set aborts any copy at once and clears error, pending interrupt and busy.
- R10: irq rises in the cycle busy falls at the end of a copy. It stays high until status is written with bit 1 (or bit 0) set.
- R11: Domain d is chosen by peripheral address bit 28. Its timing registers sit at indices 5+4d to 8+4d: address latency, strobe width, page size, release. The address strobe is high for latency+1 cycles, the read or write strobe for width+1 cycles, followed by release+1 idle cycles. The two strobes never overlap.
- R12: An address phase is issued at the first peripheral access of each fill or drain run. After that, one is issued only when the access address differs from the last one in any bit at or above bit (page size + 2).
- R13: The memory port and the peripheral bus are never active in the same cycle. A memory request holds its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWe | input | 1 | Register write strobe |
| cpuReg | input | 4 | Register word index (offset / 4) |
| cpuWdata | input | 32 | Register write data |
| cpuRdata | output | 32 | Register read data (combinational on cpuReg) |
| ioAttempt | input | 1 | Pulse: CPU is accessing peripheral space directly |
| irq | output | 1 | Transfer-complete interrupt request |
| memReq | output | 1 | Memory word request, held until memAck |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 24 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory request accepted |
| perAle | output | 1 | Peripheral address-phase strobe |
| perRdStb | output | 1 | Peripheral read strobe |
| perWrStb | output | 1 | Peripheral write strobe |
| perAddr | output | 32 | Peripheral byte address |
| perWdata | output | 16 | Peripheral write halfword |
| perRdata | input | 16 | Peripheral read halfword, sampled in the last strobe cycle |

## Verification
The hardest state to reach from the ports is a direct-access attempt that lands inside a copy long enough to need two buffer chunks. The aim is to show that the error bit latches while the data and address counts still come out right. The stimulus starts a 256-byte peripheral-to-memory copy with long strobe timing, so busy lasts thousands of cycles. Partway through, it pulses ioAttempt and also tries length and address writes. It then checks every memory word, the final addresses, and the count and width of address phases once the interrupt arrives.

// File: rtl/pbus_dma_pkg.sv
package pbus_dma_pkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic memAdv;      // memory address += 4
    logic perAdv;      // peripheral address += 2
    logic bufWe;       // write staging buffer at bufIdx
    logic bufFromMem;  // buffer write source: memory word vs assembled halfwords
    logic hiLatch;     // capture first halfword of a peripheral read
    logic pageMark;    // remember current peripheral address as open page
    logic pageClear;   // forget the open page
    logic aleOn;
    logic rdOn;
    logic wrOn;
    logic halfLo;      // drive low halfword of buffer word on writes
    logic doneStb;     // copy finished this cycle
  } ctlStrobes_t;

endpackage

// File: rtl/pbus_dma_dp.sv
module pbus_dma_dp
  import pbus_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_AW    = 24,
  parameter int LEN_W     = 24,
  parameter int BUF_WORDS = 32,
  parameter int TM_W      = 8,
  parameter int PGS_W     = 4,
  parameter int RLS_W     = 2,
  parameter int NDOM      = 2,
  parameter int DOM_BIT   = 28,
  parameter int IDX_W     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuWe,
  input  logic [IDX_W-1:0]             cpuReg,
  input  logic [31:0]                  cpuWdata,
  output logic [31:0]                  cpuRdata,
  input  logic                         ioAttempt,
  input  ctlStrobes_t                  ctl,
  input  logic [$clog2(BUF_WORDS)-1:0] bufIdx,
  input  logic                         busy,
  input  logic [31:0]                  memRdata,
  input  logic [15:0]                  perRdata,
  output logic [MEM_AW-1:0]            memAddr,
  output logic [31:0]                  memWdata,
  output logic [ADDR_W-1:0]            perAddr,
  output logic [15:0]                  perWdata,
  output logic                         irq,
  output logic                         startStb,
  output logic                         startDir,
  output logic [LEN_W-3:0]             wrLen,
  output logic                         softRst,
  output logic                         newPage,
  output logic [TM_W-1:0]              curLat,
  output logic [TM_W-1:0]              curPwd,
  output logic [TM_W-1:0]              curRls
);

  localparam int RI_MEM  = 0;
  localparam int RI_PER  = 1;
  localparam int RI_LM2P = 2;
  localparam int RI_LP2M = 3;
  localparam int RI_STAT = 4;
  localparam int RI_TIME = 5;
  localparam int DSEL_W  = (NDOM > 1) ? $clog2(NDOM) : 1;
  localparam int SH_W    = PGS_W + 1;

  logic [MEM_AW-1:0] memAddrR;
  logic [ADDR_W-1:0] perAddrR, lastAddr;
  logic [LEN_W-1:0]  lenM2P, lenP2M;
  logic              errR, irqR, pageValid;
  logic [15:0]       hiReg;
  logic [TM_W-1:0]   latR [NDOM];
  logic [TM_W-1:0]   pwdR [NDOM];
  logic [PGS_W-1:0]  pgsR [NDOM];
  logic [RLS_W-1:0]  rlsR [NDOM];
  logic [31:0]       bufMem [BUF_WORDS];
  logic [31:0]       bufRd, bufWData;
  logic [DSEL_W-1:0] domSel;
  logic [SH_W-1:0]   shAmt;
  logic              wrStat, irqClr, regOpen;

  assign regOpen  = cpuWe && !busy;
  assign wrStat   = cpuWe && (cpuReg == IDX_W'(RI_STAT));
  assign softRst  = wrStat && cpuWdata[0];
  assign irqClr   = wrStat && cpuWdata[1];
  assign startStb = regOpen && (cpuReg == IDX_W'(RI_LM2P) || cpuReg == IDX_W'(RI_LP2M));
  assign startDir = (cpuReg == IDX_W'(RI_LP2M));
  assign wrLen    = cpuWdata[LEN_W-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddrR  <= '0;
      perAddrR  <= '0;
      lenM2P    <= '0;
      lenP2M    <= '0;
      errR      <= 1'b0;
      irqR      <= 1'b0;
      hiReg     <= '0;
      pageValid <= 1'b0;
      lastAddr  <= '0;
      for (int d = 0; d < NDOM; d++) begin
        latR[d] <= '0;
        pwdR[d] <= '0;
        pgsR[d] <= '0;
        rlsR[d] <= '0;
      end
    end else begin
      if (regOpen && cpuReg == IDX_W'(RI_MEM)) memAddrR <= {cpuWdata[MEM_AW-1:1], 1'b0};
      else if (ctl.memAdv)                     memAddrR <= memAddrR + MEM_AW'(4);
      if (regOpen && cpuReg == IDX_W'(RI_PER)) perAddrR <= {cpuWdata[ADDR_W-1:1], 1'b0};
      else if (ctl.perAdv)                     perAddrR <= perAddrR + ADDR_W'(2);
      if (regOpen && cpuReg == IDX_W'(RI_LM2P)) lenM2P <= cpuWdata[LEN_W-1:0];
      if (regOpen && cpuReg == IDX_W'(RI_LP2M)) lenP2M <= cpuWdata[LEN_W-1:0];
      if (softRst)                errR <= 1'b0;
      else if (ioAttempt && busy) errR <= 1'b1;
      if (softRst)          irqR <= 1'b0;
      else if (ctl.doneStb) irqR <= 1'b1;
      else if (irqClr)      irqR <= 1'b0;
      if (ctl.hiLatch) hiReg <= perRdata;
      if (ctl.pageClear) pageValid <= 1'b0;
      else if (ctl.pageMark) begin
        pageValid <= 1'b1;
        lastAddr  <= perAddrR;
      end
      for (int d = 0; d < NDOM; d++) begin
        if (cpuWe && cpuReg == IDX_W'(RI_TIME + 4*d))     latR[d] <= cpuWdata[TM_W-1:0];
        if (cpuWe && cpuReg == IDX_W'(RI_TIME + 4*d + 1)) pwdR[d] <= cpuWdata[TM_W-1:0];
        if (cpuWe && cpuReg == IDX_W'(RI_TIME + 4*d + 2)) pgsR[d] <= cpuWdata[PGS_W-1:0];
        if (cpuWe && cpuReg == IDX_W'(RI_TIME + 4*d + 3)) rlsR[d] <= cpuWdata[RLS_W-1:0];
      end
    end
  end

  // Staging buffer: plain storage, no reset
  assign bufWData = ctl.bufFromMem ? memRdata : {hiReg, perRdata};
  always_ff @(posedge clk) begin
    if (ctl.bufWe) bufMem[bufIdx] <= bufWData;
  end
  assign bufRd    = bufMem[bufIdx];
  assign memWdata = bufRd;
  assign perWdata = ctl.halfLo ? bufRd[15:0] : bufRd[31:16];

  // Domain timing selection and page tracking
  assign domSel = perAddrR[DOM_BIT +: DSEL_W];
  assign curLat = latR[domSel];
  assign curPwd = pwdR[domSel];
  assign curRls = TM_W'(rlsR[domSel]);
  assign shAmt  = SH_W'(pgsR[domSel]) + SH_W'(2);
  assign newPage = !pageValid || (((perAddrR ^ lastAddr) >> shAmt) != '0);

  assign memAddr = memAddrR;
  assign perAddr = perAddrR;
  assign irq     = irqR;

  always_comb begin
    cpuRdata = '0;
    case (cpuReg)
      IDX_W'(RI_MEM):  cpuRdata = 32'(memAddrR);
      IDX_W'(RI_PER):  cpuRdata = 32'(perAddrR);
      IDX_W'(RI_LM2P): cpuRdata = 32'(lenM2P);
      IDX_W'(RI_LP2M): cpuRdata = 32'(lenP2M);
      IDX_W'(RI_STAT): cpuRdata = {28'd0, irqR, errR, 1'b0, busy};
      default: ;
    endcase
    for (int d = 0; d < NDOM; d++) begin
      if (cpuReg == IDX_W'(RI_TIME + 4*d))     cpuRdata = 32'(latR[d]);
      if (cpuReg == IDX_W'(RI_TIME + 4*d + 1)) cpuRdata = 32'(pwdR[d]);
      if (cpuReg == IDX_W'(RI_TIME + 4*d + 2)) cpuRdata = 32'(pgsR[d]);
      if (cpuReg == IDX_W'(RI_TIME + 4*d + 3)) cpuRdata = 32'(rlsR[d]);
    end
  end

endmodule

// File: rtl/pbus_dma_ctrl.sv
module pbus_dma_ctrl
  import pbus_dma_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int BUF_WORDS = 32,
  parameter int TM_W      = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startStb,
  input  logic                         startDir,
  input  logic [LEN_W-3:0]             wrLen,
  input  logic                         softRst,
  input  logic                         newPage,
  input  logic [TM_W-1:0]              curLat,
  input  logic [TM_W-1:0]              curPwd,
  input  logic [TM_W-1:0]              curRls,
  input  logic                         memAck,
  output logic                         memReq,
  output logic                         memWe,
  output logic                         busy,
  output ctlStrobes_t                  ctl,
  output logic [$clog2(BUF_WORDS)-1:0] bufIdx
);

  localparam int BUF_AW = $clog2(BUF_WORDS);
  localparam int WC_W   = LEN_W - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_CHUNK, S_MEM, S_PSTART, S_PALE, S_PSTB, S_PREL
  } seqState_t;

  seqState_t         state;
  logic              dirP2M, fillPh, half;
  logic [WC_W-1:0]   wordsLeft;
  logic [BUF_AW:0]   chunkN, chunkCalc;
  logic [BUF_AW-1:0] idx;
  logic [TM_W-1:0]   timer;
  logic              useMem, wordDone, lastWord, phaseEnd, tZero;

  assign tZero     = (timer == '0);
  assign useMem    = fillPh ? !dirP2M : dirP2M;
  assign lastWord  = ({1'b0, idx} == chunkN - 1'b1);
  assign chunkCalc = (wordsLeft >= WC_W'(BUF_WORDS)) ? (BUF_AW+1)'(BUF_WORDS)
                                                     : wordsLeft[BUF_AW:0];
  assign bufIdx    = idx;

  always_comb begin
    ctl            = '0;
    ctl.bufFromMem = !dirP2M;
    ctl.halfLo     = half;
    memReq         = 1'b0;
    memWe          = 1'b0;
    wordDone       = 1'b0;
    case (state)
      S_MEM: begin
        memReq = 1'b1;
        memWe  = !fillPh;
        if (memAck) begin
          ctl.memAdv = 1'b1;
          ctl.bufWe  = fillPh;
          wordDone   = 1'b1;
        end
      end
      S_PSTART: ctl.pageMark = newPage;
      S_PALE:   ctl.aleOn = 1'b1;
      S_PSTB: begin
        ctl.rdOn = fillPh;
        ctl.wrOn = !fillPh;
        if (tZero && fillPh) begin
          ctl.hiLatch = !half;
          ctl.bufWe   = half;
        end
      end
      S_PREL: begin
        if (tZero) begin
          ctl.perAdv = 1'b1;
          wordDone   = half;
        end
      end
      default: ;
    endcase
    phaseEnd      = wordDone && lastWord;
    ctl.pageClear = (state == S_CHUNK) || (phaseEnd && fillPh);
    ctl.doneStb   = phaseEnd && !fillPh && (wordsLeft == WC_W'(chunkN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      dirP2M    <= 1'b0;
      fillPh    <= 1'b0;
      half      <= 1'b0;
      wordsLeft <= '0;
      chunkN    <= '0;
      idx       <= '0;
      timer     <= '0;
    end else if (softRst) begin
      state <= S_IDLE;
      busy  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startStb) begin
          dirP2M    <= startDir;
          wordsLeft <= WC_W'(wrLen) + WC_W'(1);
          busy      <= 1'b1;
          state     <= S_CHUNK;
        end
        S_CHUNK: begin
          chunkN <= chunkCalc;
          idx    <= '0;
          half   <= 1'b0;
          fillPh <= 1'b1;
          state  <= dirP2M ? S_PSTART : S_MEM;
        end
        S_PSTART: begin
          if (newPage) begin
            timer <= curLat;
            state <= S_PALE;
          end else begin
            timer <= curPwd;
            state <= S_PSTB;
          end
        end
        S_PALE: begin
          if (tZero) begin
            timer <= curPwd;
            state <= S_PSTB;
          end else timer <= timer - 1'b1;
        end
        S_PSTB: begin
          if (tZero) begin
            timer <= curRls;
            state <= S_PREL;
          end else timer <= timer - 1'b1;
        end
        S_PREL: begin
          if (tZero) begin
            half <= !half;
            if (!half) state <= S_PSTART;
          end else timer <= timer - 1'b1;
        end
        default: ;
      endcase
      if (wordDone) begin
        if (!lastWord) begin
          idx   <= idx + 1'b1;
          state <= useMem ? S_MEM : S_PSTART;
        end else if (fillPh) begin
          fillPh <= 1'b0;
          idx    <= '0;
          state  <= dirP2M ? S_MEM : S_PSTART;
        end else begin
          wordsLeft <= wordsLeft - WC_W'(chunkN);
          if (ctl.doneStb) begin
            state <= S_IDLE;
            busy  <= 1'b0;
          end else state <= S_CHUNK;
        end
      end
    end
  end

endmodule

// File: rtl/pbus_dma.sv
module pbus_dma
  import pbus_dma_pkg::*;
#(
  parameter int MEM_AW    = 24,
  parameter int LEN_W     = 24,
  parameter int BUF_WORDS = 32,
  parameter int TM_W      = 8,
  parameter int PGS_W     = 4,
  parameter int RLS_W     = 2,
  parameter int NDOM      = 2,
  parameter int DOM_BIT   = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic [3:0]        cpuReg,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  input  logic              ioAttempt,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              perAle,
  output logic              perRdStb,
  output logic              perWrStb,
  output logic [31:0]       perAddr,
  output logic [15:0]       perWdata,
  input  logic [15:0]       perRdata
);

  localparam int BUF_AW = $clog2(BUF_WORDS);

  ctlStrobes_t       ctlW;
  logic [BUF_AW-1:0] bufIdxW;
  logic              busyW, startStbW, startDirW, softRstW, newPageW;
  logic [LEN_W-3:0]  wrLenW;
  logic [TM_W-1:0]   latW, pwdW, rlsW;

  pbus_dma_dp #(
    .ADDR_W(32), .MEM_AW(MEM_AW), .LEN_W(LEN_W), .BUF_WORDS(BUF_WORDS), .TM_W(TM_W),
    .PGS_W(PGS_W), .RLS_W(RLS_W), .NDOM(NDOM), .DOM_BIT(DOM_BIT), .IDX_W(4)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuReg(cpuReg), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .ioAttempt(ioAttempt), .ctl(ctlW), .bufIdx(bufIdxW), .busy(busyW),
    .memRdata(memRdata), .perRdata(perRdata), .memAddr(memAddr), .memWdata(memWdata),
    .perAddr(perAddr), .perWdata(perWdata), .irq(irq), .startStb(startStbW),
    .startDir(startDirW), .wrLen(wrLenW), .softRst(softRstW), .newPage(newPageW),
    .curLat(latW), .curPwd(pwdW), .curRls(rlsW)
  );

  pbus_dma_ctrl #(.LEN_W(LEN_W), .BUF_WORDS(BUF_WORDS), .TM_W(TM_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStbW), .startDir(startDirW), .wrLen(wrLenW),
    .softRst(softRstW), .newPage(newPageW), .curLat(latW), .curPwd(pwdW), .curRls(rlsW),
    .memAck(memAck), .memReq(memReq), .memWe(memWe), .busy(busyW), .ctl(ctlW),
    .bufIdx(bufIdxW)
  );

  assign perAle   = ctlW.aleOn;
  assign perRdStb = ctlW.rdOn;
  assign perWrStb = ctlW.wrOn;

endmodule

// File: rtl/pbus_dma_chk.sv
module pbus_dma_chk #(
  parameter int MEM_AW = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWe,
  input logic [3:0]        cpuReg,
  input logic [31:0]       cpuWdata,
  input logic              busy,
  input logic              irq,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [MEM_AW-1:0] memAddr,
  input logic              perAle,
  input logic              perRdStb,
  input logic              perWrStb,
  input logic [31:0]       perAddr
);

  logic statClr;
  assign statClr = cpuWe && (cpuReg == 4'd4) && (cpuWdata[1] || cpuWdata[0]);

  AST_SIDE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && (perAle || perRdStb || perWrStb))); // R13
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)); // R13
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({perAle, perRdStb, perWrStb}) <= 1); // R11
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (perRdStb || perWrStb) && $past(perRdStb || perWrStb) |-> $stable(perAddr)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !perAle && !perRdStb && !perWrStb); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irq && !statClr |=> irq); // R10
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> !busy && $past(busy)); // R10
  AST_MEM_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[0] == 1'b0); // R1

endmodule

bind pbus_dma pbus_dma_chk #(.MEM_AW(MEM_AW)) i_chk (
  .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuReg(cpuReg), .cpuWdata(cpuWdata),
  .busy(busyW), .irq(irq), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .perAle(perAle), .perRdStb(perRdStb), .perWrStb(perWrStb),
  .perAddr(perAddr)
);

// File: tb/test_pbus_dma.sv
module test_pbus_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [3:0]  cpuReg = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        ioAttempt = 1'b0;
  logic        irq, memReq, memWe, perAle, perRdStb, perWrStb;
  logic [23:0] memAddr;
  logic [31:0] memWdata, memRdata, perAddr;
  logic        memAck = 1'b0;
  logic [15:0] perWdata, perRdata;

  int total = 0;
  int bad = 0;

  logic [31:0] mem [256];
  logic [7:0]  pb [1024];
  logic [9:0]  pIdx, pIdx1;

  int aleRun = 0, lastAle = 0, aleCount = 0, stbRun = 0, lastStb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_dma i_pbus_dma (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuReg(cpuReg), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .ioAttempt(ioAttempt), .irq(irq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .perAle(perAle), .perRdStb(perRdStb), .perWrStb(perWrStb), .perAddr(perAddr),
    .perWdata(perWdata), .perRdata(perRdata)
  );

  // Memory model: acknowledge one cycle after request
  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) begin
    if (memReq && memWe && memAck) mem[memAddr[9:2]] <= memWdata;
    memAck <= memReq && !memAck;
  end

  // Peripheral model: halfword presented as {byte[a+1], byte[a]}
  assign pIdx     = perAddr[9:0];
  assign pIdx1    = pIdx + 10'd1;
  assign perRdata = {pb[pIdx1], pb[pIdx]};
  always @(posedge clk) begin
    if (perWrStb) begin
      pb[pIdx]  <= perWdata[7:0];
      pb[pIdx1] <= perWdata[15:8];
    end
    if (perAle) begin
      if (aleRun == 0) aleCount++;
      aleRun++;
    end else if (aleRun != 0) begin
      lastAle = aleRun;
      aleRun  = 0;
    end
    if (perRdStb || perWrStb) stbRun++;
    else if (stbRun != 0) begin
      lastStb = stbRun;
      stbRun  = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuReg = r; cpuWdata = d;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] r, output logic [31:0] d);
    @(negedge clk);
    cpuReg = r;
    #1 d = cpuRdata;
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(req, 32'(irq), 32'd1);
  endtask

  task automatic tReset();
    logic [31:0] v;
    regRead(4'd4, v); check("R3 status after reset", v, 32'h0);
    regRead(4'd0, v); check("R3 mem address after reset", v, 32'h0);
    check("R3 irq after reset", 32'(irq), 32'd0);
  endtask

  task automatic tMask();
    logic [31:0] v;
    regWrite(4'd0, 32'hFFFFFFFF); regRead(4'd0, v); check("R1 mem mask ones", v, 32'h00FFFFFE);
    regWrite(4'd0, 32'h55555555); regRead(4'd0, v); check("R1 mem mask 55", v, 32'h00555554);
    regWrite(4'd1, 32'hFFFFFFFF); regRead(4'd1, v); check("R2 per mask ones", v, 32'hFFFFFFFE);
    regWrite(4'd1, 32'hAAAAAAAA); regRead(4'd1, v); check("R2 per mask AA", v, 32'hAAAAAAAA);
  endtask

  task automatic tTiming();
    logic [31:0] v;
    regWrite(4'd5, 32'h80); regWrite(4'd6, 32'h20); regWrite(4'd7, 32'h6); regWrite(4'd8, 32'h3);
    regWrite(4'd9, 32'h3); regWrite(4'd10, 32'h2); regWrite(4'd11, 32'h0); regWrite(4'd12, 32'h1);
    regRead(4'd5, v); check("R11 domain0 latency readback", v, 32'h80);
    regRead(4'd10, v); check("R11 domain1 width readback", v, 32'h2);
  endtask

  task automatic tP2mLong();
    logic [31:0] v;
    int errs = 0;
    regWrite(4'd0, 32'h0);
    regWrite(4'd1, 32'h08000000);
    aleCount = 0;
    regWrite(4'd3, 32'hFF);
    regRead(4'd4, v); check("R3 busy after start", v & 32'h1, 32'h1);
    repeat (200) @(negedge clk);
    regWrite(4'd2, 32'h44);
    regRead(4'd2, v); check("R4 length write ignored while busy", v, 32'h0);
    regWrite(4'd0, 32'h300);
    ioAttempt = 1'b1;
    @(negedge clk);
    ioAttempt = 1'b0;
    regRead(4'd4, v); check("R8 error set by access while busy", v & 32'h5, 32'h5);
    waitIrq("R10 irq after long copy");
    regRead(4'd4, v); check("R3 busy clear, irq pending", v & 32'h9, 32'h8);
    for (int k = 0; k < 64; k++) begin
      logic [31:0] e;
      e = {8'(4*k+1), 8'(4*k), 8'(4*k+3), 8'(4*k+2)};
      if (mem[k] !== e) errs++;
    end
    check("R5 first stored word", mem[0], 32'h01000302);
    check("R7 all 64 words across two chunks", 32'(errs), 32'd0);
    regRead(4'd0, v); check("R7 mem address advanced (R4 write ignored)", v, 32'h100);
    regRead(4'd1, v); check("R7 per address advanced", v, 32'h08000100);
    check("R12 one address phase per fill run", 32'(aleCount), 32'd2);
    check("R11 domain0 address strobe width", 32'(lastAle), 32'h81);
    check("R11 domain0 read strobe width", 32'(lastStb), 32'h21);
    repeat (20) @(negedge clk);
    check("R10 irq held", 32'(irq), 32'd1);
    regWrite(4'd4, 32'h2);
    check("R10 irq cleared by bit1", 32'(irq), 32'd0);
    regRead(4'd4, v); check("R8 error sticky", v & 32'h4, 32'h4);
    regWrite(4'd4, 32'h1);
    regRead(4'd4, v); check("R9 soft reset clears error", v, 32'h0);
  endtask

  task automatic tIdleAccess();
    logic [31:0] v;
    @(negedge clk);
    ioAttempt = 1'b1;
    @(negedge clk);
    ioAttempt = 1'b0;
    regRead(4'd4, v); check("R8 idle access no effect", v, 32'h0);
  endtask

  task automatic tM2p();
    logic [31:0] v;
    logic [31:0] src [4];
    int errs = 0;
    src[0] = 32'h11223344; src[1] = 32'hA1B2C3D4; src[2] = 32'h55667788; src[3] = 32'hDEADBEEF;
    for (int k = 0; k < 4; k++) mem[16+k] = src[k];
    regWrite(4'd0, 32'h40);
    regWrite(4'd1, 32'h10000200);
    aleCount = 0;
    regWrite(4'd2, 32'd15);
    waitIrq("R10 irq after short copy");
    for (int k = 0; k < 4; k++) begin
      int a = 32'h200 + 4*k;
      if (pb[a] !== src[k][23:16] || pb[a+1] !== src[k][31:24] ||
          pb[a+2] !== src[k][7:0] || pb[a+3] !== src[k][15:8]) errs++;
    end
    check("R6 halfword order on writes", 32'(errs), 32'd0);
    check("R12 page crossings with 4-byte page", 32'(aleCount), 32'd4);
    check("R11 domain1 address strobe width", 32'(lastAle), 32'd4);
    check("R11 domain1 write strobe width", 32'(lastStb), 32'd3);
    regRead(4'd1, v); check("R7 per address after short copy", v, 32'h10000210);
    regRead(4'd0, v); check("R7 mem address after short copy", v, 32'h50);
    regWrite(4'd4, 32'h2);
  endtask

  task automatic tAbort();
    logic [31:0] v;
    int act = 0;
    regWrite(4'd1, 32'h10000000);
    regWrite(4'd3, 32'hFF);
    repeat (30) @(negedge clk);
    regWrite(4'd4, 32'h1);
    regRead(4'd4, v); check("R9 abort clears busy", v, 32'h0);
    repeat (40) begin
      @(negedge clk);
      if (memReq || perAle || perRdStb || perWrStb) act++;
    end
    check("R9 no activity after abort", 32'(act), 32'd0);
    check("R9 no irq after abort", 32'(irq), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) pb[i] = (i < 256) ? 8'(i) : 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMask();
    tTiming();
    tP2mLong();
    tIdleAccess();
    tM2p();
    tAbort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule